// File: doc/BRIEF.md
# Two-Level Interrupt Controller with Set and Clear Enable Ports

This block gathers up to 32 level-sensitive interrupt lines from peripherals and turns them into two processor requests: a normal request (`irq_o`) and a fast request (`fiq_o`). Each request level owns a bank of four registers: a masked status view, a live view of the raw lines, an enable mask, and a port that clears enable bits. The enable mask is only ever grown through its own address and shrunk through the clear address. Software can therefore change one source's enable without a read-modify-write sequence, and concurrent handlers cannot undo each other's changes.

A software-owned register bit feeds source position 1, so code can raise an interrupt on itself. A source enabled in both banks is routed to the fast level only. The fast bank's status bit 0 summarises all active fast sources, so a handler can test one bit. Both requests leave the block through a flop. The register bus is a plain single-cycle port with address, write strobe, write data and combinational read data.

Top module: `intc_dual_level`

## Requirements
- R1: The signal register (IRQ bank 0x004, FIQ bank 0x104) shows `src_i` live, without a clock, for the used source positions 3–6 and 10–19. Bit 1 shows the software interrupt bit. Bits 0, 2, 7–9 and 20–31 read 0. Writes to this address are ignored.
- R2: Writing to the enable address (0x008 or 0x108) sets every enable bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Only used positions can be set, where the used mask is 0x000FFC7A. The enable register reads back at the same address.
- R3: Writing to the clear address (0x00C or 0x10C) clears exactly the enable bits whose write-data bit is 1 and leaves the other enable bits unchanged. This address reads as 0.
- R4: After reset both enable masks and the software bit are 0, and `irq_o` and `fiq_o` are low.
- R5: The IRQ status (0x000) equals signal AND IRQ-enable AND NOT FIQ-enable, with bit 0 always 0. Writes to either status address are ignored.
- R6: The FIQ status (0x100) equals signal AND FIQ-enable in bits 31..1. Its bit 0 is 1 exactly when any of bits 31..1 is 1.
- R7: Bit 0 of the software register (0x010) is stored on write and reads back at 0x010. It drives bit 1 of the signal view.
- R8: A source enabled in both banks appears only in the FIQ status and can raise only `fiq_o`.
- R9: `irq_o` equals the OR of the IRQ status one clock earlier, and `fiq_o` equals the OR of the FIQ status one clock earlier. Each output rises and falls one clock after its condition changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| src_i | input | 32 | Level interrupt lines from peripherals |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
Register and status reads are combinational. The bench samples them 1 ns after it sets the address, in the low half of the clock, once the enable flop has captured the write at the previous rising edge. The two request outputs trail by exactly one rising edge. The bench therefore checks them at the falling edge after the stimulus and the edge that follows it. A directed case also checks that a request is still low just after its source rises and still high just after its source falls, before that rising edge. Random stimulus drives a bench model of both masks and the software bit, and every step compares all nine readable views and both outputs against that model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NSRC     = 32;
  localparam int unsigned AW       = 12;
  localparam logic [NSRC-1:0] USED_SRC = 32'h000F_FC7A;
  localparam int unsigned SWI_POS  = 1;
  localparam int unsigned BANK_BIT = 8;

  typedef enum logic [1:0] {
    RSEL_STAT = 2'd0,
    RSEL_SIG  = 2'd1,
    RSEL_EN   = 2'd2,
    RSEL_CLR  = 2'd3
  } rsel_e;

  localparam logic [AW-1:0] SWI_ADDR = 12'h010;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int unsigned N       = 32,
  parameter logic [N-1:0] USED   = '1,
  parameter bit          SUMMARY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] sig,
  input  logic [N-1:0] block,
  output logic [N-1:0] en_o,
  output logic [N-1:0] stat_o,
  output logic         req_o
);
  logic [N-1:0] en_q, en_d, set_m, clr_m, hit;
  logic         req_q, req_d;

  always_comb begin
    set_m = set_stb ? (wdata & USED) : '0;
    clr_m = clr_stb ? wdata : '0;
    en_d  = (en_q | set_m) & ~clr_m;
    hit   = sig & en_q & ~block;
    hit[0] = 1'b0;
    req_d = |hit;
  end

  generate
    if (SUMMARY) begin : g_sum
      always_comb stat_o = {hit[N-1:1], |hit[N-1:1]};
    end else begin : g_plain
      always_comb stat_o = {hit[N-1:1], 1'b0};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      req_q <= 1'b0;
    end else begin
      if (set_stb || clr_stb) en_q <= en_d;
      req_q <= req_d;
    end
  end

  assign en_o  = en_q;
  assign req_o = req_q;

  // R3
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en_q & $past(wdata)) == '0));
  // R2
  set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb) |=> ((en_q & $past(wdata) & USED) == ($past(wdata) & USED)));
  // R2
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> (($past(en_q) & ~en_q) == '0));
endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               we,
  input  logic [N-1:0]       wdata,
  input  logic [N-1:0]       sig,
  input  logic [1:0][N-1:0]  en_all,
  input  logic [1:0][N-1:0]  stat_all,
  output logic [1:0]         set_stb,
  output logic [1:0]         clr_stb,
  output logic               swi_o,
  output logic [N-1:0]       rdata
);
  logic  bank_hit, swi_hit, bidx, swi_q, swi_d;
  rsel_e rsel;

  always_comb begin
    bank_hit = (addr[AW-1:BANK_BIT+1] == '0) && (addr[BANK_BIT-1:4] == '0)
               && (addr[1:0] == 2'b00);
    bidx     = addr[BANK_BIT];
    rsel     = rsel_e'(addr[3:2]);
    swi_hit  = (addr == SWI_ADDR);
    set_stb  = '0;
    clr_stb  = '0;
    if (we && bank_hit && rsel == RSEL_EN)  set_stb[bidx] = 1'b1;
    if (we && bank_hit && rsel == RSEL_CLR) clr_stb[bidx] = 1'b1;
    swi_d = (we && swi_hit) ? wdata[0] : swi_q;
  end

  always_comb begin
    rdata = '0;
    if (bank_hit) begin
      unique case (rsel)
        RSEL_STAT: rdata = stat_all[bidx];
        RSEL_SIG:  rdata = sig;
        RSEL_EN:   rdata = en_all[bidx];
        RSEL_CLR:  rdata = '0;
      endcase
    end else if (swi_hit) begin
      rdata[0] = swi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swi_q <= 1'b0;
    else        swi_q <= swi_d;
  end

  assign swi_o = swi_q;

  // R7
  swi_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && swi_hit) |=> (swi_q == $past(wdata[0])));
endmodule

// File: rtl/intc_dual_level.sv
module intc_dual_level
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int unsigned NB = 2;
  localparam logic [NSRC-1:0] SWI_ONEHOT = NSRC'(1) << SWI_POS;

  logic [1:0]            rst_pipe;
  logic                  rst_s;
  logic [NB-1:0]         set_stb, clr_stb, req;
  logic [NB-1:0][NSRC-1:0] en_all, stat_all;
  logic [NSRC-1:0]       sig;
  logic                  swi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  always_comb begin
    sig = (src_i & USED_SRC & ~SWI_ONEHOT) | (swi ? SWI_ONEHOT : '0);
  end

  intc_regif #(.N(NSRC), .AW(AW)) u_regif (
    .clk(clk), .rst_n(rst_s), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .sig(sig), .en_all(en_all), .stat_all(stat_all),
    .set_stb(set_stb), .clr_stb(clr_stb), .swi_o(swi), .rdata(bus_rdata)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [NSRC-1:0] blk;
    assign blk = (g == 0) ? en_all[1] : '0;
    intc_bank #(.N(NSRC), .USED(USED_SRC), .SUMMARY(g == 1)) u_bank (
      .clk(clk), .rst_n(rst_s), .set_stb(set_stb[g]), .clr_stb(clr_stb[g]),
      .wdata(bus_wdata), .sig(sig), .block(blk),
      .en_o(en_all[g]), .stat_o(stat_all[g]), .req_o(req[g])
    );
  end

  assign irq_o = req[0];
  assign fiq_o = req[1];

  // R8
  level_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ((stat_all[0] & stat_all[1]) & ~NSRC'(1)) == '0);
  // R9
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (irq_o == $past(|stat_all[0])));
  // R6
  fiq_summary_chk: assert property (@(posedge clk) disable iff (!rst_s)
    stat_all[1][0] |=> fiq_o);
  // R5
  irq_bit0_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !stat_all[0][0]);
endmodule

// File: tb/sim_intc_dual_level.sv
module sim_intc_dual_level;
  localparam logic [31:0] USED = 32'h000F_FC7A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int unsigned n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] m_ien = '0, m_fen = '0;
  logic        m_swi = 1'b0;

  intc_dual_level u0 (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] f_sig();
    return (src_i & USED & ~32'h2) | {30'd0, m_swi, 1'b0};
  endfunction
  function automatic logic [31:0] f_ist();
    logic [31:0] v = f_sig() & m_ien & ~m_fen;
    v[0] = 1'b0;
    return v;
  endfunction
  function automatic logic [31:0] f_fst();
    logic [31:0] v = f_sig() & m_fen;
    v[0] = |v[31:1];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      12'h008: m_ien = m_ien | (d & USED);
      12'h108: m_fen = m_fen | (d & USED);
      12'h00C: m_ien = m_ien & ~d;
      12'h10C: m_fen = m_fen & ~d;
      12'h010: m_swi = d[0];
      default: ;
    endcase
  endtask

  task automatic check_all();
    logic [31:0] v;
    rd(12'h004, v); chk("R1 sig", v, f_sig());
    rd(12'h104, v); chk("R1 fiq-bank sig", v, f_sig());
    rd(12'h008, v); chk("R2 irq en", v, m_ien);
    rd(12'h108, v); chk("R2 fiq en", v, m_fen);
    rd(12'h00C, v); chk("R3 irq clr reads 0", v, 32'h0);
    rd(12'h10C, v); chk("R3 fiq clr reads 0", v, 32'h0);
    rd(12'h000, v); chk("R5 irq stat", v, f_ist());
    rd(12'h100, v); chk("R6 fiq stat", v, f_fst());
    rd(12'h010, v); chk("R7 swi", v, {31'd0, m_swi});
    @(negedge clk);
    chk("R9 irq_o", {31'd0, irq_o}, {31'd0, |f_ist()});
    chk("R9 fiq_o", {31'd0, fiq_o}, {31'd0, |f_fst()});
  endtask

  localparam logic [11:0] ADDRS [9] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
                                        12'h100, 12'h104, 12'h108, 12'h10C};

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R4 reset state
    chk("R4 irq_o", {31'd0, irq_o}, 32'd0);
    chk("R4 fiq_o", {31'd0, fiq_o}, 32'd0);
    check_all();

    // R2 writing 0 to set port changes nothing; unused bits not settable
    wr(12'h008, 32'h0000_0008);
    wr(12'h008, 32'h0);
    check_all();
    wr(12'h008, 32'hFFFF_FFFF);
    check_all();
    // R3 clear one bit only
    wr(12'h00C, 32'h0000_0008);
    check_all();
    wr(12'h00C, 32'hFFFF_FFFF);

    // R9 timing on source bit 3
    wr(12'h008, 32'h0000_0008);
    @(negedge clk);
    src_i = 32'h0000_0008; #1;
    chk("R9 irq_o not yet", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R9 irq_o rose", {31'd0, irq_o}, 32'd1);
    src_i = 32'h0; #1;
    chk("R9 irq_o still high", {31'd0, irq_o}, 32'd1);
    @(negedge clk);
    chk("R9 irq_o fell", {31'd0, irq_o}, 32'd0);

    // R8 precedence: bit 3 enabled in both banks
    src_i = 32'h0000_0008;
    wr(12'h108, 32'h0000_0008);
    check_all();
    chk("R8 irq_o low", {31'd0, irq_o}, 32'd0);
    chk("R8 fiq_o high", {31'd0, fiq_o}, 32'd1);
    // R1/R5 writes to signal and status ignored
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    check_all();
    // R7 software interrupt
    wr(12'h010, 32'h1);
    wr(12'h008, 32'h2);
    check_all();
    chk("R7 irq_o via swi", {31'd0, irq_o}, 32'd1);
    wr(12'h010, 32'h0);
    check_all();

    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 9);
      if (op == 9) begin
        @(negedge clk);
        src_i = $urandom();
      end else begin
        logic [31:0] d = ($urandom_range(0, 3) == 0) ? $urandom() : (32'h1 << $urandom_range(0, 31));
        wr(ADDRS[op], d);
      end
      check_all();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule